// File: doc/BRIEF.md
# DDR3 Power-Down Timing Guard

This block sits beside the command scheduler of a DDR3 memory controller. It decides when the clock-enable pin may be pulled low to put the DRAM into power-down, how long the DRAM must stay there, and when commands may follow the wake-up. Every command the scheduler issues is shown on a one-cycle strobe, with a type code and a flag that marks burst-chop-4 as fixed by the mode register. Each command sets a minimum wait before entry. The wait depends on the command type and the burst mode. A single countdown holds the latest of these earliest-entry points.

The scheduler raises `pd_req` to ask for entry and `pd_wake` to ask for exit. The guard drives `cke` itself. It keeps each clock-enable level for at least the programmed minimum pulse width. It counts how long the DRAM has been in power-down and forces an exit before the residence limit. After an exit it opens two command-permit outputs. One is for commands that work without a locked DLL and the other is for commands that need one. Every nanosecond-based minimum arrives as a clock count that has already been rounded up, so the hardware does no clock-period arithmetic. There is no data stream here: the scheduler's strobe is never stalled, and all pins are plain control and status.

Top module: `ddr3_pd_guard`

## Requirements
- R1: After reset `cke` is 1, `force_exit` is 0, `cmd_ok_nodll` and `cmd_ok_dll` are 1, and `entry_ok` is 1 while no command is strobed.
- R2: Command codes on `cmd_type` are ACT=0, PRE=1, RD=2, RDA=3, WR=4, WRA=5, REF=6, MRS=7. A command strobed in cycle k drives `entry_ok` low through cycle k+D-1, and `entry_ok` is high again in cycle k+D. For ACT, PRE and REF, D is 1.
- R3: For RD and RDA, D = `cfg_rl` + 5.
- R4: When `cmd_bc4_fixed` is 0, D = `cfg_wl` + 4 + `cfg_twr` for WR and D = `cfg_wl` + 4 + `cfg_wr` + 1 for WRA.
- R5: When `cmd_bc4_fixed` is 1, the WR and WRA delays use `cfg_wl` + 2 in place of `cfg_wl` + 4.
- R6: For MRS, D = `cfg_tmod`.
- R7: A later command with a shorter D never shortens a wait that is still running from an earlier command.
- R8: `entry_ok` is 0 in any cycle where `cmd_valid` is 1. `cke` falls at the clock edge that ends a cycle in which both `pd_req` and `entry_ok` are 1.
- R9: Each level of `cke` lasts at least `cfg_tcke` cycles. A wake request made right after entry gives exactly `cfg_tcke` low cycles. A re-entry request held from the first high cycle gives exactly `cfg_tcke` high cycles.
- R10: With no wake request, `cke` stays low for exactly `cfg_res_limit` cycles. `force_exit` is 1 only in the last of those cycles and only while `cke` is low.
- R11: If `cke` rises at edge x, `cmd_ok_nodll` is high from the cycle that ends at edge x+`cfg_txp`, and `cmd_ok_dll` is high from the cycle that ends at edge x+`cfg_txpdll`.
- R12: While `cke` is low, both command-permit outputs are 0. This makes command issue disabled from the entry edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_type | input | 3 | Command code (see R2) |
| cmd_bc4_fixed | input | 1 | Burst-chop-4 fixed by mode register |
| cfg_rl | input | CFG_W | Read latency in clocks |
| cfg_wl | input | CFG_W | Write latency in clocks |
| cfg_twr | input | CFG_W | Write recovery time in clocks (plain write) |
| cfg_wr | input | CFG_W | Write recovery setting for auto-precharge |
| cfg_tmod | input | CFG_W | Mode-register-set settle time in clocks |
| cfg_tcke | input | CFG_W | Minimum clock-enable pulse width in clocks |
| cfg_txp | input | CFG_W | Exit wait for commands that do not need a locked DLL |
| cfg_txpdll | input | CFG_W | Exit wait for commands that need a locked DLL |
| cfg_res_limit | input | RES_W | Maximum power-down residence in clocks |
| pd_req | input | 1 | Scheduler asks for power-down entry |
| pd_wake | input | 1 | Scheduler asks for power-down exit |
| cke | output | 1 | Clock-enable to the DRAM |
| entry_ok | output | 1 | Entry would be legal at the coming edge |
| force_exit | output | 1 | Residence limit reached; exit is being forced |
| cmd_ok_nodll | output | 1 | Commands that do not need a locked DLL may issue |
| cmd_ok_dll | output | 1 | Commands that need a locked DLL may issue |

## Verification
A countdown that loads the wrong value, or that lets a newer command overwrite an older one, moves the first cycle in which `entry_ok` is high. The bench measures that cycle after every command kind, so the error shows within one wait window of the faulty command. A broken pulse-width or residence counter moves the `cke` edges by whole cycles at the next entry or exit. A wake timer that is off by one moves the rising edge of a permit output within `cfg_txpdll` cycles of the exit.

// File: rtl/pdg_pkg.sv
package pdg_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0,
    CMD_PRE = 3'd1,
    CMD_RD  = 3'd2,
    CMD_RDA = 3'd3,
    CMD_WR  = 3'd4,
    CMD_WRA = 3'd5,
    CMD_REF = 3'd6,
    CMD_MRS = 3'd7
  } pdg_cmd_e;
endpackage

// File: rtl/pdg_entry_delay.sv
module pdg_entry_delay #(
  parameter int CFG_W = 6,
  parameter int DLY_W = CFG_W + 3
) (
  input  logic [2:0]       cmd_type,
  input  logic             bc4_fixed,
  input  logic [CFG_W-1:0] cfg_rl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_twr,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_tmod,
  output logic [DLY_W-1:0] dly
);
  import pdg_pkg::*;
  localparam int PAD = DLY_W - CFG_W;

  logic [DLY_W-1:0] rl_x, wl_x, twr_x, wr_x, tmod_x, wl_tail;
  pdg_cmd_e kind;

  assign rl_x   = {{PAD{1'b0}}, cfg_rl};
  assign wl_x   = {{PAD{1'b0}}, cfg_wl};
  assign twr_x  = {{PAD{1'b0}}, cfg_twr};
  assign wr_x   = {{PAD{1'b0}}, cfg_wr};
  assign tmod_x = {{PAD{1'b0}}, cfg_tmod};
  assign kind   = pdg_cmd_e'(cmd_type);
  // write data tail: chop-4 fixed by mode register is two clocks shorter
  assign wl_tail = bc4_fixed ? (wl_x + DLY_W'(2)) : (wl_x + DLY_W'(4));

  always_comb begin
    unique case (kind)
      CMD_RD, CMD_RDA: dly = rl_x + DLY_W'(5);
      CMD_WR:          dly = wl_tail + twr_x;
      CMD_WRA:         dly = wl_tail + wr_x + DLY_W'(1);
      CMD_MRS:         dly = tmod_x;
      default:         dly = DLY_W'(1);
    endcase
  end
endmodule

// File: rtl/pdg_countdown.sv
module pdg_countdown #(
  parameter int W        = 8,
  parameter int KEEP_MAX = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, dec, nxt;

  assign dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);

  generate
    if (KEEP_MAX != 0) begin : g_keep_max
      // a newer, shorter wait never replaces a longer running one
      always_comb nxt = (load && (load_val > dec)) ? load_val : dec;
    end else begin : g_plain
      always_comb nxt = load ? load_val : dec;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= nxt;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr3_pd_guard.sv
module ddr3_pd_guard #(
  parameter int CFG_W = 6,
  parameter int RES_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_type,
  input  logic             cmd_bc4_fixed,
  input  logic [CFG_W-1:0] cfg_rl,
  input  logic [CFG_W-1:0] cfg_wl,
  input  logic [CFG_W-1:0] cfg_twr,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_tmod,
  input  logic [CFG_W-1:0] cfg_tcke,
  input  logic [CFG_W-1:0] cfg_txp,
  input  logic [CFG_W-1:0] cfg_txpdll,
  input  logic [RES_W-1:0] cfg_res_limit,
  input  logic             pd_req,
  input  logic             pd_wake,
  output logic             cke,
  output logic             entry_ok,
  output logic             force_exit,
  output logic             cmd_ok_nodll,
  output logic             cmd_ok_dll
);
  localparam int DLY_W  = CFG_W + 3;
  localparam int WAKE_N = 2;

  logic             cke_q;
  logic [CFG_W-1:0] pw_cnt;
  logic [RES_W-1:0] res_cnt;
  logic [DLY_W-1:0] dly, blk_val;
  logic             blk_zero, pw_ok, res_hit, go_down, go_up;
  logic [CFG_W-1:0] wake_cfg [WAKE_N];
  logic [WAKE_N-1:0] wake_zero;

  pdg_entry_delay #(.CFG_W(CFG_W), .DLY_W(DLY_W)) u_dly (
    .cmd_type (cmd_type),
    .bc4_fixed(cmd_bc4_fixed),
    .cfg_rl   (cfg_rl),
    .cfg_wl   (cfg_wl),
    .cfg_twr  (cfg_twr),
    .cfg_wr   (cfg_wr),
    .cfg_tmod (cfg_tmod),
    .dly      (dly)
  );

  // counter holds the cycles still to wait after the current one
  assign blk_val = (dly == '0) ? '0 : dly - DLY_W'(1);

  pdg_countdown #(.W(DLY_W), .KEEP_MAX(1)) u_block (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cmd_valid && cke_q),
    .load_val(blk_val),
    .zero    (blk_zero)
  );

  // level width and residence tracking
  assign pw_ok   = ({1'b0, pw_cnt} + (CFG_W+1)'(1)) >= {1'b0, cfg_tcke};
  assign res_hit = ({1'b0, res_cnt} + (RES_W+1)'(1)) >= {1'b0, cfg_res_limit};

  assign entry_ok   = cke_q && blk_zero && !cmd_valid && pw_ok;
  assign force_exit = !cke_q && res_hit;
  assign go_down    = pd_req && entry_ok;
  assign go_up      = !cke_q && (pd_wake || force_exit) && pw_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cke_q   <= 1'b1;
      pw_cnt  <= '1;
      res_cnt <= '0;
    end else begin
      if (go_down)      cke_q <= 1'b0;
      else if (go_up)   cke_q <= 1'b1;

      if (go_down || go_up)  pw_cnt <= '0;
      else if (pw_cnt != '1) pw_cnt <= pw_cnt + CFG_W'(1);

      if (go_down)                        res_cnt <= '0;
      else if (!cke_q && res_cnt != '1)   res_cnt <= res_cnt + RES_W'(1);
    end
  end

  // exit wake-up timers: index 0 no DLL needed, index 1 locked DLL needed
  assign wake_cfg[0] = cfg_txp;
  assign wake_cfg[1] = cfg_txpdll;

  generate
    for (genvar i = 0; i < WAKE_N; i++) begin : g_wake
      logic [CFG_W-1:0] wval;
      assign wval = (wake_cfg[i] == '0) ? '0 : wake_cfg[i] - CFG_W'(1);
      pdg_countdown #(.W(CFG_W), .KEEP_MAX(0)) u_wake (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (go_up),
        .load_val(wval),
        .zero    (wake_zero[i])
      );
    end
  endgenerate

  assign cke          = cke_q;
  assign cmd_ok_nodll = cke_q && wake_zero[0];
  assign cmd_ok_dll   = cke_q && wake_zero[1];
endmodule

// File: rtl/pdg_chk.sv
module pdg_chk #(
  parameter int CFG_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             pd_req,
  input logic             pd_wake,
  input logic             cke,
  input logic             entry_ok,
  input logic             force_exit,
  input logic             cmd_ok_nodll,
  input logic             cmd_ok_dll,
  input logic [CFG_W-1:0] cfg_txp,
  input logic [CFG_W-1:0] cfg_txpdll
);
  // R8
  cke_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(pd_req && entry_ok));
  // R8
  cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !entry_ok);
  // R12
  down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (!cmd_ok_nodll && !cmd_ok_dll));
  // R10
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_exit |-> !cke);
  // R9
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> $past(pd_wake || force_exit));
  // R11
  dll_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ok_dll && (cfg_txpdll >= cfg_txp)) |-> cmd_ok_nodll);
endmodule

bind ddr3_pd_guard pdg_chk #(.CFG_W(CFG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .pd_req      (pd_req),
  .pd_wake     (pd_wake),
  .cke         (cke),
  .entry_ok    (entry_ok),
  .force_exit  (force_exit),
  .cmd_ok_nodll(cmd_ok_nodll),
  .cmd_ok_dll  (cmd_ok_dll),
  .cfg_txp     (cfg_txp),
  .cfg_txpdll  (cfg_txpdll)
);

// File: tb/sim_ddr3_pd_guard.sv
module sim_ddr3_pd_guard;
  localparam int CLK_PERIOD = 10;
  localparam int CFG_W = 6;
  localparam int RES_W = 16;
  localparam int RL = 6, WL = 5, TWR = 6, WRC = 7, TMOD = 12;
  localparam int TCKE = 3, TXP = 4, TXPDLL = 10, RES_LIM = 40;
  localparam int VEC_N = 10;
  // {cmd_type, bc4_fixed, expected delay}
  localparam logic [15:0] VEC [VEC_N] = '{
    {3'd0, 1'b0, 12'd1},
    {3'd1, 1'b0, 12'd1},
    {3'd6, 1'b0, 12'd1},
    {3'd2, 1'b0, 12'(RL + 5)},
    {3'd3, 1'b0, 12'(RL + 5)},
    {3'd4, 1'b0, 12'(WL + 4 + TWR)},
    {3'd5, 1'b0, 12'(WL + 4 + WRC + 1)},
    {3'd4, 1'b1, 12'(WL + 2 + TWR)},
    {3'd5, 1'b1, 12'(WL + 2 + WRC + 1)},
    {3'd7, 1'b0, 12'(TMOD)}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_type = 3'd0;
  logic cmd_bc4_fixed = 1'b0;
  logic pd_req = 1'b0, pd_wake = 1'b0;
  logic cke, entry_ok, force_exit, cmd_ok_nodll, cmd_ok_dll;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr3_pd_guard #(.CFG_W(CFG_W), .RES_W(RES_W)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
    .cmd_bc4_fixed(cmd_bc4_fixed),
    .cfg_rl(CFG_W'(RL)), .cfg_wl(CFG_W'(WL)), .cfg_twr(CFG_W'(TWR)),
    .cfg_wr(CFG_W'(WRC)), .cfg_tmod(CFG_W'(TMOD)), .cfg_tcke(CFG_W'(TCKE)),
    .cfg_txp(CFG_W'(TXP)), .cfg_txpdll(CFG_W'(TXPDLL)),
    .cfg_res_limit(RES_W'(RES_LIM)),
    .pd_req(pd_req), .pd_wake(pd_wake), .cke(cke), .entry_ok(entry_ok),
    .force_exit(force_exit), .cmd_ok_nodll(cmd_ok_nodll), .cmd_ok_dll(cmd_ok_dll)
  );

  task automatic check(input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // strobe one command; return cycles until entry_ok is high again
  task automatic cmd_gap(input logic [2:0] t, input logic b, output int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = t; cmd_bc4_fixed = b;
    #1 check(int'(entry_ok), 0, "R8 entry_ok low with command");
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    #1;
    while (!entry_ok && n < 80) begin
      @(negedge clk); #1; n++;
    end
  endtask

  // request entry on a cycle with entry_ok high
  task automatic enter_pd();
    @(negedge clk); #1;
    while (!entry_ok) begin @(negedge clk); #1; end
    pd_req = 1'b1;
    @(negedge clk); #1;
    pd_req = 1'b0;
    check(int'(cke), 0, "R8 cke low after request");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    finish_run();
  end

  initial begin
    int n, lows, highs, xp_low, dll_low;
    logic last_force, first_force;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(int'(cke), 1, "R1 cke");
    check(int'(force_exit), 0, "R1 force_exit");
    check(int'(cmd_ok_nodll), 1, "R1 cmd_ok_nodll");
    check(int'(cmd_ok_dll), 1, "R1 cmd_ok_dll");
    check(int'(entry_ok), 1, "R1 entry_ok");

    // R2 R3 R4 R5 R6 per-command entry delay table
    for (int i = 0; i < VEC_N; i++) begin
      cmd_gap(VEC[i][15:13], VEC[i][12], n);
      check(n, int'(VEC[i][11:0]), $sformatf("R2-6 delay vector %0d", i));
    end

    // R7 long WRA followed by short ACT keeps the long wait
    @(negedge clk);
    cmd_valid = 1'b1; cmd_type = 3'd5; cmd_bc4_fixed = 1'b0;
    @(negedge clk); cmd_valid = 1'b0;
    n = 1;
    repeat (2) begin @(negedge clk); n++; end
    cmd_valid = 1'b1; cmd_type = 3'd0;
    @(negedge clk); cmd_valid = 1'b0; n++;
    #1;
    while (!entry_ok && n < 80) begin @(negedge clk); #1; n++; end
    check(n, WL + 4 + WRC + 1, "R7 older wait kept");

    // R9 low width with immediate wake, R12 quiet while down
    enter_pd();
    check(int'(cmd_ok_nodll), 0, "R12 nodll low while down");
    check(int'(cmd_ok_dll), 0, "R12 dll low while down");
    pd_wake = 1'b1;
    lows = 1;
    @(negedge clk); #1;
    while (!cke && lows < 80) begin @(negedge clk); #1; lows++; end
    pd_wake = 1'b0;
    check(lows, TCKE, "R9 low width");

    // R11 wake timers, current negedge is first cycle after the rising edge
    xp_low = 0; dll_low = 0;
    for (int k = 0; k < 16; k++) begin
      if (!cmd_ok_nodll) xp_low++;
      if (!cmd_ok_dll) dll_low++;
      @(negedge clk); #1;
    end
    check(xp_low, TXP - 1, "R11 no-DLL wait");
    check(dll_low, TXPDLL - 1, "R11 DLL wait");

    // R9 high width: wake then request entry from the first high cycle
    enter_pd();
    pd_wake = 1'b1;
    @(negedge clk); #1;
    while (!cke) begin @(negedge clk); #1; end
    pd_wake = 1'b0;
    pd_req = 1'b1;
    highs = 1;
    @(negedge clk); #1;
    while (cke && highs < 80) begin @(negedge clk); #1; highs++; end
    pd_req = 1'b0;
    check(highs, TCKE, "R9 high width");

    // R10 forced exit after the residence limit (already down here)
    lows = 1; first_force = force_exit; last_force = force_exit;
    @(negedge clk); #1;
    while (!cke && lows < 200) begin
      last_force = force_exit; lows++;
      @(negedge clk); #1;
    end
    check(lows, RES_LIM, "R10 residence length");
    check(int'(first_force), 0, "R10 no early force");
    check(int'(last_force), 1, "R10 force in last cycle");
    check(int'(force_exit), 0, "R10 force drops when up");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule